// File: doc/BRIEF.md
# Shared-Wire Bus Slave with Block Transfers

This block is a slave on a synchronous bus that carries address and data on one set of wires. A master opens a transaction with a one-cycle `start` pulse. In that cycle it drives an operation code and an address word on the shared wires. The slave checks whether the request falls inside its address window. It then either stores or returns words from an internal register array, or it refuses the request. It ends every transaction by pulsing `finish` and placing a status code on the operation lines.

The shared wires are modelled as three ports: an input from the bus (`ad_in`), a value to drive (`ad_out`) and a drive enable (`ad_oe`). The operation lines use the same scheme (`op_in`, `op_out`, `op_oe`). A fixed number of wait states (parameter `WAIT_ST`, default 2) delays every completion. With no wait states, a single-word access takes three clocks. Block operations carry a word count. The slave generates the consecutive addresses itself, and block data moves at one word per clock.

Top module: `mbs_slave`

## Requirements
- R1: Out of reset, `finish`, `op_oe` and `ad_oe` are low, and `op_out` and `ad_out` read zero. They stay that way while no transaction is open.
- R2: A `start` pulse is taken only when no transaction is open. A `start` raised during an open transaction, including its finish cycle, changes neither its timing nor its results.
- R3: Address word layout: bits [7:0] hold the address and bits [11:8] hold the word count minus one. Operation codes: 1 = single read, 2 = single write, 3 = block read, 4 = block write. A single write stores the word that is on `ad_in` in cycle 1. Cycle 0 is the start cycle. The slave finishes in cycle `WAIT_ST`+2 with status 1 (OK). Single operations ignore the count field.
- R4: A single read drives the stored word with `ad_oe` high, `finish` high and status OK in cycle `WAIT_ST`+2.
- R5: `ad_oe` and `finish` stay low in cycle 1 (the turnaround or write-data cycle) and in all cycles up to `WAIT_ST`+1. The slave drives data only while `ad_oe` is high, and only alongside `op_oe`.
- R6: A block write of N words stores the words from cycles 1..N at addresses A, A+1, ... A+N-1. It finishes with OK in cycle N+1+`WAIT_ST`.
- R7: A block read of N words returns word A+k in cycle `WAIT_ST`+2+k. Every word except the last carries status 4 (continue) with `finish` low. The last word carries OK with `finish` high.
- R8: The window is the 16 words at 0x40..0x4F. Any request whose first or last word lies outside the window ends with status 2 (fail) in cycle `WAIT_ST`+2. It returns no data and stores nothing.
- R9: A block request in the window with more than `MAX_BURST` (8) words ends with status 3 (retry) in cycle `WAIT_ST`+2 and stores nothing. A window failure takes priority over retry.
- R10: Operation codes 0, 5, 6 and 7 end with status 2 (fail) in cycle `WAIT_ST`+2 and store nothing.
- R11: `finish` is high for exactly one cycle per transaction. A status other than continue appears only together with `finish`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Master opens a transaction this cycle |
| op_in | input | 3 | Operation code driven by the master |
| op_out | output | 3 | Status code driven by the slave |
| op_oe | output | 1 | Slave drives the operation lines |
| ad_in | input | 16 | Value seen on the shared address/data wires |
| ad_out | output | 16 | Read data the slave drives |
| ad_oe | output | 1 | Slave drives the shared wires |
| finish | output | 1 | Transaction ends this cycle |

## Verification
The bench first fills every window word with single writes. About half of these writes are made while `start` is toggled during the open transaction. Single reads of all sixteen words then separate a correct data path from an off-by-one in the read-issue cycle or in the turnaround. Block writes and reads of every length from 1 to 8, at shifting offsets, show whether the slave steps its addresses correctly and marks the last word correctly. Out-of-window, window-crossing, overlong and illegal-opcode requests are each followed by read-back of the affected words. This distinguishes "refused and untouched" from "refused but partly stored", and it confirms that failure takes priority over retry.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam logic [2:0] OP_RD   = 3'd1;
  localparam logic [2:0] OP_WR   = 3'd2;
  localparam logic [2:0] OP_RBLK = 3'd3;
  localparam logic [2:0] OP_WBLK = 3'd4;

  localparam logic [2:0] ST_OK    = 3'd1;
  localparam logic [2:0] ST_FAIL  = 3'd2;
  localparam logic [2:0] ST_RETRY = 3'd3;
  localparam logic [2:0] ST_CONT  = 3'd4;
endpackage

// File: rtl/mbs_decode.sv
module mbs_decode
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 4,
  parameter int LOC_W = 4,
  parameter logic [ADDR_W-1:0] BASE = 'h40,
  parameter int MAX_BURST = 8
) (
  input  logic [2:0]              op,
  input  logic [ADDR_W+CNT_W-1:0] word,
  output logic                    is_rd,
  output logic [CNT_W:0]          nwords,
  output logic [LOC_W-1:0]        idx,
  output logic [2:0]              status
);
  localparam logic [CNT_W:0] ONE_N = 1;
  localparam logic [CNT_W:0] MAXB = (CNT_W+1)'(MAX_BURST);
  localparam logic [ADDR_W-LOC_W:0] WIN_HI = {1'b0, BASE[ADDR_W-1:LOC_W]};

  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cfield;
  logic [ADDR_W:0]   last_a;
  logic              legal, blk, in_win;

  always_comb begin
    addr   = word[ADDR_W-1:0];
    cfield = word[ADDR_W+CNT_W-1:ADDR_W];
    legal  = op inside {OP_RD, OP_WR, OP_RBLK, OP_WBLK};
    blk    = (op == OP_RBLK) || (op == OP_WBLK);
    is_rd  = (op == OP_RD) || (op == OP_RBLK);
    nwords = blk ? ({1'b0, cfield} + ONE_N) : ONE_N;
    last_a = {1'b0, addr} + (ADDR_W+1)'(nwords) - (ADDR_W+1)'(1);
    in_win = (addr[ADDR_W-1:LOC_W] == BASE[ADDR_W-1:LOC_W]) &&
             (last_a[ADDR_W:LOC_W] == WIN_HI);
    idx    = addr[LOC_W-1:0];
    if (!legal || !in_win)
      status = ST_FAIL;
    else if (blk && (nwords > MAXB))
      status = ST_RETRY;
    else
      status = ST_OK;
  end
endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
  parameter int DATA_W = 16,
  parameter int LOC_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LOC_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [LOC_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << LOC_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LOC_W = 4,
  parameter int WAIT_ST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dec_rd,
  input  logic [CNT_W:0]   dec_n,
  input  logic [LOC_W-1:0] dec_idx,
  input  logic [2:0]       dec_st,
  output logic             busy,
  output logic             we,
  output logic [LOC_W-1:0] widx,
  output logic             re,
  output logic [LOC_W-1:0] ridx,
  output logic             finish,
  output logic             op_oe,
  output logic [2:0]       op_out,
  output logic             ad_oe
);
  localparam int PH_W = $clog2((1 << CNT_W) + WAIT_ST + 3);
  localparam int CW = (PH_W > LOC_W) ? PH_W : LOC_W;
  localparam logic [CW-1:0] ONE = 1;
  localparam logic [CW-1:0] RD_LO = CW'(WAIT_ST + 2);
  localparam logic [CW-1:0] FIN_GAP = CW'(WAIT_ST + 1);

  logic [CW-1:0]    ph, p_nx, last, n_ext;
  logic             rd_q;
  logic [CNT_W:0]   n_q;
  logic [LOC_W-1:0] base_q;
  logic [2:0]       st_q;
  logic             ok, at_last;
  logic             fin_n, rdwin_n, opoe_n, adoe_n;
  logic [2:0]       code_n;

  always_comb begin
    ok      = (st_q == ST_OK);
    n_ext   = CW'(n_q);
    last    = n_ext + FIN_GAP;
    at_last = (ph == last);
    p_nx    = ph + ONE;
    fin_n   = (p_nx == last);
    rdwin_n = rd_q && ok && (p_nx >= RD_LO) && (p_nx <= last);
    opoe_n  = (rd_q && ok) ? rdwin_n : fin_n;
    adoe_n  = rdwin_n;
    code_n  = opoe_n ? (fin_n ? st_q : ST_CONT) : 3'd0;
    re      = busy && !at_last && rdwin_n;
    ridx    = base_q + LOC_W'(p_nx - RD_LO);
    we      = busy && !rd_q && ok && (ph >= ONE) && (ph <= n_ext);
    widx    = base_q + LOC_W'(ph - ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ph     <= '0;
      rd_q   <= 1'b0;
      n_q    <= '0;
      base_q <= '0;
      st_q   <= ST_OK;
      finish <= 1'b0;
      op_oe  <= 1'b0;
      op_out <= 3'd0;
      ad_oe  <= 1'b0;
    end else if (!busy) begin
      finish <= 1'b0;
      op_oe  <= 1'b0;
      op_out <= 3'd0;
      ad_oe  <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        ph     <= ONE;
        rd_q   <= dec_rd;
        n_q    <= (dec_st == ST_OK) ? dec_n : (CNT_W+1)'(1);
        base_q <= dec_idx;
        st_q   <= dec_st;
      end
    end else if (at_last) begin
      busy   <= 1'b0;
      finish <= 1'b0;
      op_oe  <= 1'b0;
      op_out <= 3'd0;
      ad_oe  <= 1'b0;
    end else begin
      ph     <= p_nx;
      finish <= fin_n;
      op_oe  <= opoe_n;
      op_out <= code_n;
      ad_oe  <= adoe_n;
    end
  end
endmodule

// File: rtl/mbs_slave.sv
module mbs_slave #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CNT_W = 4,
  parameter int LOC_W = 4,
  parameter logic [ADDR_W-1:0] BASE = 'h40,
  parameter int WAIT_ST = 2,
  parameter int MAX_BURST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op_in,
  output logic [2:0]        op_out,
  output logic              op_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              finish
);
  logic             dec_rd;
  logic [CNT_W:0]   dec_n;
  logic [LOC_W-1:0] dec_idx;
  logic [2:0]       dec_st;
  logic             busy_w, we, re;
  logic [LOC_W-1:0] widx, ridx;
  logic [DATA_W-1:0] rdata;

  mbs_decode #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOC_W(LOC_W),
    .BASE(BASE), .MAX_BURST(MAX_BURST)
  ) u_dec (
    .op(op_in), .word(ad_in[ADDR_W+CNT_W-1:0]),
    .is_rd(dec_rd), .nwords(dec_n), .idx(dec_idx), .status(dec_st)
  );

  mbs_ctrl #(
    .CNT_W(CNT_W), .LOC_W(LOC_W), .WAIT_ST(WAIT_ST)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .dec_rd(dec_rd), .dec_n(dec_n), .dec_idx(dec_idx), .dec_st(dec_st),
    .busy(busy_w), .we(we), .widx(widx), .re(re), .ridx(ridx),
    .finish(finish), .op_oe(op_oe), .op_out(op_out), .ad_oe(ad_oe)
  );

  mbs_regfile #(
    .DATA_W(DATA_W), .LOC_W(LOC_W)
  ) u_mem (
    .clk(clk), .we(we), .widx(widx), .wdata(ad_in),
    .re(re), .ridx(ridx), .rdata(rdata)
  );

  assign ad_out = ad_oe ? rdata : '0;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker
  import mbs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       finish,
  input logic       op_oe,
  input logic       ad_oe,
  input logic [2:0] op_out
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!finish && !op_oe && !ad_oe));

  a_r5_gap_undriven: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!ad_oe && !finish));

  a_r5_data_with_status: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> op_oe);

  a_r11_finish_pulse: assert property (@(posedge clk) disable iff (rst)
    finish |=> !finish);

  a_r11_final_status_on_finish: assert property (@(posedge clk) disable iff (rst)
    (op_oe && op_out != ST_CONT) |-> finish);

  a_r7_cont_carries_data: assert property (@(posedge clk) disable iff (rst)
    (op_oe && op_out == ST_CONT) |-> (ad_oe && !finish));

  a_r8_refusal_no_data: assert property (@(posedge clk) disable iff (rst)
    (finish && op_out != ST_OK) |-> !ad_oe);

  a_r11_finish_drives_ops: assert property (@(posedge clk) disable iff (rst)
    finish |-> op_oe);
endmodule

bind mbs_slave mbs_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy_w),
  .finish(finish), .op_oe(op_oe), .ad_oe(ad_oe), .op_out(op_out)
);

// File: tb/sim_mbs_slave.sv
`timescale 1ns/1ps
module sim_mbs_slave;
  localparam int WAIT = 2;
  localparam logic [2:0] C_OK = 3'd1, C_FAIL = 3'd2, C_RETRY = 3'd3, C_CONT = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] op_in = 3'd0;
  logic [15:0] ad_in = 16'd0;
  logic [2:0] op_out;
  logic op_oe, ad_oe, finish;
  logic [15:0] ad_out;

  int errors = 0, checks = 0, seq = 0;
  bit done = 1'b0;
  logic [15:0] ref_mem [16];

  always #2 clk = ~clk;

  mbs_slave #(.WAIT_ST(WAIT)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_in(op_in), .op_out(op_out),
    .op_oe(op_oe), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .finish(finish)
  );

  function automatic logic [2:0] exp_status(logic [2:0] op, logic [7:0] addr, int len);
    int n, first, lst;
    bit blk;
    if (op < 3'd1 || op > 3'd4) return C_FAIL;
    blk = (op >= 3'd3);
    n = blk ? len : 1;
    first = int'(addr);
    lst = first + n - 1;
    if (first / 16 != 4 || lst / 16 != 4) return C_FAIL;
    if (blk && n > 8) return C_RETRY;
    return C_OK;
  endfunction

  task automatic check(input string tag, input int p, input logic [21:0] act, input logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, p, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] addr, input int len,
                     input bit poke, input string tag);
    logic [2:0] st, eop;
    int n, last, idx;
    bit rd, blk, ok, efin, eadoe, eopoe;
    logic [15:0] wd [16];
    logic [15:0] edat;
    st = exp_status(op, addr, len);
    rd = (op == 3'd1) || (op == 3'd3);
    blk = (op == 3'd3) || (op == 3'd4);
    ok = (st == C_OK);
    n = ok ? (blk ? len : 1) : 1;
    last = n + 1 + WAIT;
    for (int i = 0; i < 16; i++) begin
      wd[i] = 16'hA000 ^ 16'(seq * 311);
      seq++;
    end
    for (int p = 0; p <= last; p++) begin
      if (p == 0) begin
        start = 1'b1;
        op_in = op;
        ad_in = {4'h0, 4'(len - 1), addr};
      end else begin
        start = poke;
        op_in = poke ? 3'd1 : 3'd0;
        if (!rd && p <= len && p <= 16) ad_in = wd[p-1];
        else ad_in = poke ? 16'h0041 : 16'h0000;
      end
      efin = (p == last);
      eadoe = rd && ok && (p >= WAIT + 2);
      eopoe = (rd && ok) ? eadoe : efin;
      eop = eopoe ? (efin ? st : C_CONT) : 3'd0;
      idx = (int'(addr[3:0]) + p - WAIT - 2) & 15;
      edat = eadoe ? ref_mem[idx] : 16'h0000;
      if (p == 0)
        check("R11 quiet between transactions", p, {finish, op_oe, ad_oe, op_out, ad_out}, 22'd0);
      else if (p < WAIT + 2)
        check("R5 no drive in gap", p, {finish, op_oe, ad_oe, op_out, ad_out}, 22'd0);
      else
        check(tag, p, {finish, op_oe, ad_oe, op_out, ad_out}, {efin, eopoe, eadoe, eop, edat});
      @(posedge clk); #1;
    end
    start = 1'b0;
    op_in = 3'd0;
    ad_in = 16'h0000;
    if (ok && !rd)
      for (int i = 0; i < n; i++) ref_mem[(int'(addr[3:0]) + i) & 15] = wd[i];
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    check("R1 reset state", 0, {finish, op_oe, ad_oe, op_out, ad_out}, 22'd0);

    for (int a = 0; a < 16; a++)
      run(3'd2, 8'(8'h40 + a), (a % 3 == 0) ? 6 : 1, a[0], "R3 single write (R2 start ignored)");
    for (int a = 0; a < 16; a++)
      run(3'd1, 8'(8'h40 + a), (a % 4 == 0) ? 9 : 1, a[1], "R4 single read");

    for (int len = 1; len <= 8; len++)
      run(3'd4, 8'(8'h40 + (len * 5) % (17 - len)), len, len[0], "R6 block write");
    for (int a = 0; a < 16; a++)
      run(3'd1, 8'(8'h40 + a), 1, 1'b0, "R6 block write read-back");
    for (int len = 1; len <= 8; len++)
      run(3'd3, 8'(8'h40 + (len * 3) % (17 - len)), len, len[1], "R7 block read");

    run(3'd2, 8'h3F, 1, 1'b0, "R8 write below window");
    run(3'd2, 8'h50, 1, 1'b1, "R8 write above window");
    run(3'd2, 8'h00, 1, 1'b0, "R8 write far outside");
    run(3'd1, 8'hFF, 1, 1'b0, "R8 read outside");
    run(3'd4, 8'h4E, 4, 1'b0, "R8 block write crossing end");
    run(3'd3, 8'h4C, 8, 1'b0, "R8 block read crossing end");
    run(3'd4, 8'h4A, 9, 1'b0, "R9 fail beats retry");
    for (int len = 9; len <= 16; len++)
      run(3'd4, 8'h40, len, 1'b0, "R9 overlong block retry");
    run(3'd3, 8'h40, 12, 1'b0, "R9 overlong block read retry");
    run(3'd0, 8'h44, 1, 1'b0, "R10 opcode 0");
    run(3'd5, 8'h45, 1, 1'b0, "R10 opcode 5");
    run(3'd6, 8'h46, 1, 1'b1, "R10 opcode 6");
    run(3'd7, 8'h47, 1, 1'b0, "R10 opcode 7");
    for (int a = 0; a < 16; a++)
      run(3'd1, 8'(8'h40 + a), 1, 1'b0, "R8 R9 R10 nothing stored");
    run(3'd3, 8'h40, 8, 1'b1, "R7 block read final");

    check("R11 idle after last", 0, {finish, op_oe, ad_oe, op_out, ad_out}, 22'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule